// File: doc/BRIEF.md
# Compare/Capture Event Timer

This block holds two 8-bit timer channels. Each channel has a count register and a match register. Counting is paced by one of several power-of-two divisions of the system clock, or by rising edges on an external event pin. In timer mode the count runs up to the match value. On the next tick it returns to zero, gives a one-cycle interrupt pulse and flips a square-wave compare output.

In capture mode the match register becomes a capture register. A chosen edge on the channel's capture pin loads the running count into it and restarts the count from zero. The count wraps freely at full scale, and no match is raised.

Channel 0 can join the two channels into one 16-bit counter with a 16-bit match/capture value. Channel 0's settings then govern both halves. Software reaches the block through write strobes with a channel select, and reads back the count and match values directly.

Top module: `evtmr_top`

## Requirements
- R1: After reset, every count, match value, interrupt pulse and compare output reads zero, and no channel counts.
- R2: A control write takes effect at the clock edge that samples it. Control word bits: [0] run, [1] clear, [4:2] tick source, [5] capture mode, [7:6] capture edge, [8] join (channel 0 only). Source code 0 counts rising edges of the event pin after a two-flop synchroniser. Codes 1..7 divide the clock by 2, 4, 8, 32, 128, 512 and 2048, using a prescaler that runs freely from reset. A tick for a division of 2^k occurs when the low k prescaler bits are all one. Counting happens only while run is set.
- R3: In timer mode, a tick that finds count equal to the match value sets the count to zero and raises that channel's interrupt for exactly one cycle, so the period is (match+1) ticks. For example, divide-by-32 with a match value of 124 gives 4000 clocks.
- R4: The compare output toggles on every match, giving a 50:50 square wave at half the match rate.
- R5: A control write with the clear bit set zeroes the count at that same edge. Clear wins over a tick or a capture, and it suppresses a match pulse in that cycle.
- R6: In capture mode a selected edge on the capture pin, seen after a two-flop synchroniser and while run is set, copies the current count into the match register and zeroes the count. Ticks make the count wrap from FF to 00, with no interrupt and no compare toggle.
- R7: The capture edge field selects 0 = rising, 1 = falling, 2 or 3 = both edges.
- R8: A capture and a software write to the same channel's match register in one cycle leave the captured count in the register.
- R9: With join set, the counter {ch1,ch0} and the match value {ch1,ch0} act as one 16-bit channel using channel 0's source, run, mode, edge and capture pin. The 16-bit channel reports its interrupt and compare output on bit 0. Bit 1 interrupt stays low, and a clear on either channel zeroes all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pin | input | 2 | External event clock pin per channel |
| cap_pin | input | 2 | Capture trigger pin per channel |
| wr_sel | input | 1 | Channel addressed by a write |
| wr_ctrl | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 9 | Control word (layout in R2) |
| wr_data | input | 1 | Write strobe for the match register |
| data_wdata | input | 8 | Match value to write |
| cnt_o | output | 16 | Counts, channel 1 in the upper byte |
| dat_o | output | 16 | Match/capture values, channel 1 in the upper byte |
| irq_o | output | 2 | One-cycle match pulse per channel |
| cmp_o | output | 2 | Compare square-wave output per channel |

## Verification
Two collisions matter here. A capture can land in the same cycle as a software write of the match register, and a clear can land in the same cycle as a tick or a match. The bench provokes the first by counting the synchroniser delay, so that the pin edge becomes effective at the very edge where the data write strobe is sampled. It then requires the captured count, not the written value. It provokes the second by issuing clears while fast ticks are running, and requires a zero count with no interrupt pulse at that edge. A cycle-level reference model, built from the requirements, also judges every other cycle of the randomised traffic.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

  localparam int CTRL_W = 9;
  localparam int SRC_W  = 3;

  typedef enum logic [1:0] {
    EDG_RISE  = 2'd0,
    EDG_FALL  = 2'd1,
    EDG_BOTH  = 2'd2,
    EDG_BOTHB = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic             join_en;
    edge_sel_e        edg;
    logic             capm;
    logic [SRC_W-1:0] src;
    logic             run;
  } chan_ctl_t;

  // log2 of the prescaler division selected by a tick-source code
  function automatic int src_shift(input int code);
    case (code)
      1:       return 1;
      2:       return 2;
      3:       return 3;
      4:       return 5;
      5:       return 7;
      6:       return 9;
      7:       return 11;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/evtmr_prescale.sv
module evtmr_prescale
  import evtmr_pkg::*;
#(
  parameter int PRE_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [(1<<SRC_W)-1:0] tap_o
);
  localparam int NSRC = 1 << SRC_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb pre_d = pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tap_o[0] = 1'b0;

  for (genvar c = 1; c < NSRC; c++) begin : g_tap
    localparam int K = src_shift(c);
    if (K <= PRE_W) begin : g_ok
      assign tap_o[c] = &pre_q[K-1:0];
    end else begin : g_none
      assign tap_o[c] = 1'b0;
    end
  end

endmodule

// File: rtl/evtmr_pinedge.sv
module evtmr_pinedge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC-1:0] sync_q;
  logic [SYNC-1:0] sync_d;
  logic            prev_q;

  always_comb begin
    sync_d = {sync_q[SYNC-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign rise_o =  sync_q[SYNC-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC-1] &  prev_q;

endmodule

// File: rtl/evtmr_lane.sv
module evtmr_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero_i,
  input  logic         inc_i,
  input  logic         cap_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] dat_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] dat_q, dat_d;
  logic         cnt_en, dat_en;

  always_comb begin
    cnt_en = zero_i | inc_i;
    cnt_d  = zero_i ? '0 : cnt_q + 1'b1;
    dat_en = cap_i | wr_i;
    dat_d  = cap_i ? cnt_q : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dat_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (dat_en) dat_q <= dat_d;
    end
  end

  assign cnt_o = cnt_q;
  assign dat_o = dat_q;

endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE_W = 11,
  parameter int SYNC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ev_pin,
  input  logic [1:0]      cap_pin,
  input  logic            wr_sel,
  input  logic            wr_ctrl,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic            wr_data,
  input  logic [W-1:0]    data_wdata,
  output logic [2*W-1:0]  cnt_o,
  output logic [2*W-1:0]  dat_o,
  output logic [1:0]      irq_o,
  output logic [1:0]      cmp_o
);
  localparam int NCH  = 2;
  localparam int NSRC = 1 << SRC_W;

  chan_ctl_t ctl_q [NCH];
  chan_ctl_t ctl_d [NCH];
  logic [NSRC-1:0] tap;
  logic [NCH-1:0]  ev_rise, ev_fall, cp_rise, cp_fall;
  logic [NCH-1:0]  tick, capev, clr_req;
  logic [NCH-1:0]  ln_zero, ln_inc, ln_cap, ln_wr;
  logic [W-1:0]    ln_cnt [NCH];
  logic [W-1:0]    ln_dat [NCH];
  logic [NCH-1:0]  hit;
  logic [NCH-1:0]  irq_q, cmp_q;
  logic            joined;
  logic [NCH-1:0]  capm_vec;

  evtmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tap_o (tap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    evtmr_pinedge #(.SYNC(SYNC)) u_ev (
      .clk(clk), .rst_n(rst_n), .pin_i(ev_pin[i]),
      .rise_o(ev_rise[i]), .fall_o(ev_fall[i])
    );
    evtmr_pinedge #(.SYNC(SYNC)) u_cp (
      .clk(clk), .rst_n(rst_n), .pin_i(cap_pin[i]),
      .rise_o(cp_rise[i]), .fall_o(cp_fall[i])
    );
    evtmr_lane #(.W(W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .zero_i(ln_zero[i]), .inc_i(ln_inc[i]), .cap_i(ln_cap[i]),
      .wr_i(ln_wr[i]), .wdata_i(data_wdata),
      .cnt_o(ln_cnt[i]), .dat_o(ln_dat[i])
    );

    always_comb begin
      logic src_hit;
      logic edge_hit;
      src_hit = (ctl_q[i].src == '0) ? ev_rise[i] : tap[ctl_q[i].src];
      tick[i] = ctl_q[i].run & src_hit;
      case (ctl_q[i].edg)
        EDG_RISE: edge_hit = cp_rise[i];
        EDG_FALL: edge_hit = cp_fall[i];
        default:  edge_hit = cp_rise[i] | cp_fall[i];
      endcase
      capev[i]   = ctl_q[i].run & ctl_q[i].capm & edge_hit;
      clr_req[i] = wr_ctrl & (wr_sel == 1'(i)) & ctrl_wdata[1];
      ln_wr[i]   = wr_data & (wr_sel == 1'(i));
      capm_vec[i] = ctl_q[i].capm;
    end

    // control register: next-state
    always_comb begin
      ctl_d[i] = ctl_q[i];
      if (wr_ctrl && (wr_sel == 1'(i))) begin
        ctl_d[i].run     = ctrl_wdata[0];
        ctl_d[i].src     = ctrl_wdata[4:2];
        ctl_d[i].capm    = ctrl_wdata[5];
        ctl_d[i].edg     = edge_sel_e'(ctrl_wdata[7:6]);
        ctl_d[i].join_en = (i == 0) ? ctrl_wdata[8] : 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[i] <= '0;
      else        ctl_q[i] <= ctl_d[i];
    end
  end

  assign joined = ctl_q[0].join_en;

  // lane sequencing: split or cascaded
  always_comb begin
    logic clr_any;
    logic match16;
    logic [NCH-1:0] match8;
    ln_zero = '0;
    ln_inc  = '0;
    ln_cap  = '0;
    hit     = '0;
    clr_any = |clr_req;
    match16 = tick[0] & ~ctl_q[0].capm &
              ({ln_cnt[1], ln_cnt[0]} == {ln_dat[1], ln_dat[0]});
    for (int i = 0; i < NCH; i++) begin
      match8[i] = tick[i] & ~ctl_q[i].capm & (ln_cnt[i] == ln_dat[i]);
    end
    if (joined) begin
      ln_cap  = {NCH{capev[0]}};
      ln_zero = {NCH{clr_any | capev[0] | match16}};
      ln_inc[0] = tick[0];
      ln_inc[1] = tick[0] & (&ln_cnt[0]);
      hit[0]    = match16 & ~clr_any;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        ln_cap[i]  = capev[i];
        ln_zero[i] = clr_req[i] | capev[i] | match8[i];
        ln_inc[i]  = tick[i];
        hit[i]     = match8[i] & ~clr_req[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      cmp_q <= '0;
    end else begin
      irq_q <= hit;
      cmp_q <= cmp_q ^ hit;
    end
  end

  assign cnt_o = {ln_cnt[1], ln_cnt[0]};
  assign dat_o = {ln_dat[1], ln_dat[0]};
  assign irq_o = irq_q;
  assign cmp_o = cmp_q;

endmodule

// File: rtl/evtmr_chk.sv
module evtmr_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*W-1:0] cnt_i,
  input logic [1:0]     irq_i,
  input logic [1:0]     cmp_i,
  input logic           joined_i,
  input logic [1:0]     capm_i
);

  a_r3_irq_lo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i[0] |-> (cnt_i[W-1:0] == '0));

  a_r3_irq_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i[1] |-> (cnt_i[2*W-1:W] == '0));

  a_r4_toggle_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_i[0]) |-> irq_i[0]);

  a_r4_toggle_hi: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_i[1]) |-> irq_i[1]);

  a_r6_cap_quiet_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $past(capm_i[0]) |-> !irq_i[0]);

  a_r6_cap_quiet_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $past(capm_i[1]) |-> !irq_i[1]);

  a_r9_hi_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(joined_i) |-> !irq_i[1]);

  a_r9_wide_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(joined_i) && irq_i[0]) |-> (cnt_i == '0));

endmodule

bind evtmr_top evtmr_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_i    (cnt_o),
  .irq_i    (irq_o),
  .cmp_i    (cmp_o),
  .joined_i (joined),
  .capm_i   (capm_vec)
);

// File: tb/evtmr_top_tb.sv
module evtmr_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ev_pin, cap_pin;
  logic        wr_sel, wr_ctrl, wr_data;
  logic [8:0]  ctrl_wdata;
  logic [7:0]  data_wdata;
  logic [15:0] cnt_o, dat_o;
  logic [1:0]  irq_o, cmp_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 0;
  bit run_chk = 0;
  string ctx = "R1";

  evtmr_top u_dut (
    .clk(clk), .rst_n(rst_n), .ev_pin(ev_pin), .cap_pin(cap_pin),
    .wr_sel(wr_sel), .wr_ctrl(wr_ctrl), .ctrl_wdata(ctrl_wdata),
    .wr_data(wr_data), .data_wdata(data_wdata),
    .cnt_o(cnt_o), .dat_o(dat_o), .irq_o(irq_o), .cmp_o(cmp_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  logic [10:0] m_pre;
  logic [1:0]  es1, es2, ep, cs1, cs2, cpv;
  logic        m_run [2];
  logic [2:0]  m_src [2];
  logic        m_capm [2];
  logic [1:0]  m_edg [2];
  logic        m_join;
  logic [7:0]  m_cnt [2];
  logic [7:0]  m_dat [2];
  logic [1:0]  m_irq, m_cmp;

  function automatic bit tapf(input logic [10:0] p, input logic [2:0] s);
    case (s)
      3'd1: return p[0];
      3'd2: return &p[1:0];
      3'd3: return &p[2:0];
      3'd4: return &p[4:0];
      3'd5: return &p[6:0];
      3'd6: return &p[8:0];
      3'd7: return &p[10:0];
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= '0; es1 <= '0; es2 <= '0; ep <= '0;
      cs1 <= '0; cs2 <= '0; cpv <= '0;
      m_join <= 0; m_irq <= '0; m_cmp <= '0;
      for (int i = 0; i < 2; i++) begin
        m_run[i] <= 0; m_src[i] <= '0; m_capm[i] <= 0; m_edg[i] <= '0;
        m_cnt[i] <= '0; m_dat[i] <= '0;
      end
    end else begin
      logic [1:0] tk, ce, cl, hit, capl;
      logic [7:0] nc [2];
      logic [7:0] nd [2];
      logic [15:0] c16, d16;
      bit cr, cf;
      hit = '0;
      for (int i = 0; i < 2; i++) begin
        tk[i] = m_run[i] && ((m_src[i] == 0) ? (es2[i] & ~ep[i]) : tapf(m_pre, m_src[i]));
        cr = cs2[i] & ~cpv[i];
        cf = ~cs2[i] & cpv[i];
        ce[i] = m_run[i] && m_capm[i] &&
                ((m_edg[i] == 0) ? cr : (m_edg[i] == 1) ? cf : (cr | cf));
        cl[i] = wr_ctrl && (wr_sel == 1'(i)) && ctrl_wdata[1];
        nc[i] = m_cnt[i];
        nd[i] = m_dat[i];
      end
      if (m_join) begin
        c16 = {m_cnt[1], m_cnt[0]};
        d16 = {m_dat[1], m_dat[0]};
        if (cl != 0) c16 = 0;
        else if (ce[0]) c16 = 0;
        else if (tk[0]) begin
          if (!m_capm[0] && c16 == d16) begin c16 = 0; hit[0] = 1; end
          else c16 = c16 + 1;
        end
        if (tk[0] && !m_capm[0] && {m_cnt[1], m_cnt[0]} == d16) c16 = 0;
        nc[0] = c16[7:0]; nc[1] = c16[15:8];
        capl = {ce[0], ce[0]};
      end else begin
        for (int i = 0; i < 2; i++) begin
          if (cl[i]) nc[i] = 0;
          else if (ce[i]) nc[i] = 0;
          else if (tk[i]) begin
            if (!m_capm[i] && m_cnt[i] == m_dat[i]) begin nc[i] = 0; hit[i] = 1; end
            else nc[i] = m_cnt[i] + 1;
          end
        end
        capl = ce;
      end
      for (int i = 0; i < 2; i++) begin
        if (capl[i]) nd[i] = m_cnt[i];
        else if (wr_data && wr_sel == 1'(i)) nd[i] = data_wdata;
        m_cnt[i] <= nc[i];
        m_dat[i] <= nd[i];
      end
      if (wr_ctrl) begin
        m_run[wr_sel]  <= ctrl_wdata[0];
        m_src[wr_sel]  <= ctrl_wdata[4:2];
        m_capm[wr_sel] <= ctrl_wdata[5];
        m_edg[wr_sel]  <= ctrl_wdata[7:6];
        if (wr_sel == 0) m_join <= ctrl_wdata[8];
      end
      m_irq <= hit;
      m_cmp <= m_cmp ^ hit;
      m_pre <= m_pre + 1;
      es1 <= ev_pin;  es2 <= es1; ep <= es2;
      cs1 <= cap_pin; cs2 <= cs1; cpv <= cs2;
    end
  end

  // cycle-by-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && run_chk && !done) begin
      chk(cnt_o == {m_cnt[1], m_cnt[0]}, ctx, "count", cnt_o, {m_cnt[1], m_cnt[0]});
      chk(dat_o == {m_dat[1], m_dat[0]}, ctx, "match value", dat_o, {m_dat[1], m_dat[0]});
      chk(irq_o == m_irq, ctx, "irq", irq_o, m_irq);
      chk(cmp_o == m_cmp, ctx, "compare out", cmp_o, m_cmp);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr_c(input bit ch, input logic [8:0] v);
    wr_sel = ch; ctrl_wdata = v; wr_ctrl = 1;
    @(negedge clk);
    wr_ctrl = 0;
  endtask

  task automatic wr_d(input bit ch, input logic [7:0] v);
    wr_sel = ch; data_wdata = v; wr_data = 1;
    @(negedge clk);
    wr_data = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    int seed;
    int gap;
    logic [1:0] cmp_a;
    seed = 1234;
    void'($urandom(seed));
    rst_n = 0; ev_pin = 0; cap_pin = 0; wr_sel = 0; wr_ctrl = 0;
    wr_data = 0; ctrl_wdata = 0; data_wdata = 0;
    #(CLK_PERIOD*3 + CLK_PERIOD/4);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(cnt_o == 0, "R1", "count after reset", cnt_o, 0);
    chk(dat_o == 0, "R1", "match after reset", dat_o, 0);
    chk(irq_o == 0 && cmp_o == 0, "R1", "irq/cmp after reset", {irq_o, cmp_o}, 0);
    idle(20);
    chk(cnt_o == 0, "R1", "idle count without run", cnt_o, 0);
    run_chk = 1;

    // R2: every tick source, event pin toggling at random
    ctx = "R2";
    for (int s = 0; s < 8; s++) begin
      wr_d(0, 8'd3); wr_d(1, 8'd6);
      wr_c(0, 9'(1 | (s << 2)));
      wr_c(1, 9'(1 | (((s + 3) % 8) << 2)));
      for (int k = 0; k < 600; k++) begin
        if ($urandom % 3 == 0) ev_pin = 2'($urandom);
        @(negedge clk);
      end
    end

    // R3 + R4: divide-by-32 with 124 gives 4000 clocks; compare output toggles
    ctx = "R3";
    wr_c(0, 9'h000);
    wr_d(1, 8'd124);
    wr_c(1, 9'(1 | 2 | (4 << 2)));
    while (!irq_o[1]) @(negedge clk);
    cmp_a = cmp_o;
    gap = 0;
    do begin @(negedge clk); gap++; end while (!irq_o[1] && gap < 5000);
    chk(gap == 4000, "R3", "interrupt period", gap, 4000);
    chk(cmp_o[1] != cmp_a[1], "R4", "compare toggled at match", cmp_o[1], ~cmp_a[1]);
    ctx = "R4";
    wr_d(1, 8'd0);
    wr_c(1, 9'(1 | 2 | (1 << 2)));
    idle(40);

    // R5: clear while fast ticking, collides with ticks and matches
    ctx = "R5";
    wr_d(0, 8'd2);
    wr_c(0, 9'(1 | (1 << 2)));
    for (int k = 0; k < 12; k++) begin
      idle(k + 1);
      wr_c(0, 9'(1 | 2 | (1 << 2)));
      chk(cnt_o[7:0] == 0, "R5", "count after clear", cnt_o[7:0], 0);
      chk(irq_o[0] == 0, "R5", "no match pulse on clear edge", irq_o[0], 0);
    end

    // R6: capture on rising edge, with wrap of the free count
    ctx = "R6";
    wr_c(1, 9'h000);
    wr_c(0, 9'(1 | 2 | (1 << 2) | (1 << 5)));
    idle(700);
    for (int k = 0; k < 6; k++) begin
      cap_pin[0] = ~cap_pin[0];
      idle(20 + 13 * k);
    end

    // R7: falling and both-edge capture on channel 1
    ctx = "R7";
    wr_c(1, 9'(1 | 2 | (2 << 2) | (1 << 5) | (1 << 6)));
    for (int k = 0; k < 8; k++) begin cap_pin[1] = ~cap_pin[1]; idle(37); end
    wr_c(1, 9'(1 | 2 | (2 << 2) | (1 << 5) | (2 << 6)));
    for (int k = 0; k < 8; k++) begin cap_pin[1] = ~cap_pin[1]; idle(29); end

    // R8: capture edge effective at the same edge as a match write
    ctx = "R8";
    cap_pin[0] = 0;
    wr_c(0, 9'(1 | 2 | (1 << 2) | (1 << 5)));
    idle(30);
    cap_pin[0] = 1;            // sync 2 flops + edge: acted on 3rd rising edge
    @(negedge clk);
    @(negedge clk);
    wr_sel = 0; data_wdata = 8'hAA; wr_data = 1;
    @(negedge clk);
    wr_data = 0;
    chk(dat_o[7:0] != 8'hAA, "R8", "capture wins over write", dat_o[7:0], m_dat[0]);
    chk(dat_o[7:0] == m_dat[0], "R8", "captured count", dat_o[7:0], m_dat[0]);
    idle(10);

    // R9: joined 16-bit timer, then joined capture
    ctx = "R9";
    wr_d(0, 8'h10); wr_d(1, 8'h01);
    wr_c(1, 9'(1 | (1 << 2)));
    wr_c(0, 9'(9'h100 | 1 | 2 | (1 << 2)));
    idle(1800);
    wr_c(1, 9'(1 | 2 | (1 << 2)));
    idle(20);
    wr_c(0, 9'(9'h100 | 1 | 2 | (1 << 2) | (1 << 5)));
    for (int k = 0; k < 5; k++) begin cap_pin[0] = ~cap_pin[0]; idle(300); end

    // randomised traffic, all requirements judged by the model
    ctx = "R2";
    for (int k = 0; k < 25000; k++) begin
      if ($urandom % 40 == 0) begin
        wr_sel = 1'($urandom);
        ctrl_wdata = 9'($urandom);
        ctrl_wdata[4:2] = 3'($urandom % 4);
        if ($urandom % 4 != 0) ctrl_wdata[8] = 0;
        if ($urandom % 3 != 0) ctrl_wdata[1] = 0;
        wr_ctrl = 1;
      end
      if ($urandom % 40 == 0) begin
        wr_sel = 1'($urandom);
        data_wdata = 8'($urandom % 24);
        wr_data = 1;
      end
      if ($urandom % 6 == 0) ev_pin = 2'($urandom);
      if ($urandom % 15 == 0) cap_pin = 2'($urandom);
      @(negedge clk);
      wr_ctrl = 0; wr_data = 0;
    end
    finish_run();
  end

endmodule